// File: doc/BRIEF.md
# String Block Operation Sequencer

This block carries out block-string operations over a simple synchronous memory port. A caller presents an operation code, an element size and three register values: a destination or scan pointer (R1), a source pointer or comparison value (R2) and an element count (R3). It then pulses `start`. The sequencer walks through memory one element at a time. It moves the two pointers and counts the count down as it goes, and it ends each operation with a one-cycle `done` pulse. The updated register values and the zero and carry conditions are then ready on its outputs for the caller to write back.

Seven operations are supported:

- byte compare, which stops on a difference or on a NUL byte;
- fill, which stores the R2 value repeatedly;
- byte copy forward;
- byte copy backward;
- byte copy that stops once a NUL byte has been copied;
- scan that stops on an element equal to R2;
- scan that stops on an element that differs from R2.

Each operation has its own termination rule and its own way of forming the condition outputs. Fill and the two scans work on 8, 16 or 32-bit elements.

The memory port has one-cycle read latency. For a read issued with `memRe` high, the element at `memAddr`, zero-extended to 32 bits at the width given by `memSize`, appears on `memRdata` in the following cycle. Address translation and memory faults are handled outside.

Top module: `str_engine`

## Requirements
- R1: When `start` is accepted with R3 = 0, with `elemSize` = 3 or with `opcode` = 7, `done` pulses in the cycle after the start cycle. No memory access is made, and the register outputs take the loaded values while the zero and carry outputs keep their previous values.
- R2: Compare (opcode 0) reads one byte at R1, then one byte at R2. Per pair it adds 1 to both pointers and subtracts 1 from R3. It stops after a pair that differs, after a pair whose R1 byte is zero, or when R3 reaches zero.
- R3: After a compare with R3 nonzero at start, `flagZ` is 1 when the last two bytes were equal. `flagC` is 1 when the last R1 byte is greater than or equal to the last R2 byte, compared unsigned.
- R4: Fill (opcode 1) writes the low bytes of R2 at R1, little-endian, with the size encoding 0 = byte, 1 = 16-bit, 2 = 32-bit. It advances R1 by 1, 2 or 4 per element and subtracts 1 from R3 until R3 is zero, and it leaves the flags unchanged.
- R5: Forward copy (opcode 2) and backward copy (opcode 3) read the byte at R2 and write it at R1. Both pointers then step by +1 (forward) or -1 (backward), R3 drops by 1 per byte, and the operation stops at R3 = 0. Flags are unchanged.
- R6: Copy-until-NUL (opcode 4) copies forward like opcode 2. It stops right after a zero byte has been written, even when R3 is not yet zero.
- R7: Scan-until (opcode 5) reads elements of the size given in R4's encoding at R1. It advances R1 by the element width and subtracts 1 from R3, and it stops on an element equal to the full 32-bit R2 or at R3 = 0. Afterwards `flagZ` is 1 when the last element equals R2, and `flagC` is 1 when it is at most R2, compared unsigned.
- R8: Scan-while (opcode 6) steps like opcode 5 but stops on an element that differs from R2 or at R3 = 0. Afterwards `flagZ` is 1 exactly when R3 is zero, and `flagC` is 1 when the last element is at most R2, compared unsigned.
- R9: `done` is high for exactly one cycle per operation. `busy` is high from the cycle after the start cycle until `done` has been given. A `start` while busy is ignored, and the flags change only while busy.
- R10: Read and write are never requested in the same cycle. An operation of n elements takes 1 + n*k cycles from the start edge to `done`, where k is 3 for compare, 1 for fill and 2 for copy and scan.
- R11: After reset all register outputs and flags are 0, and `done`, `busy`, `memRe` and `memWe` are low.
- R12: While busy, R3 changes only by a decrement of exactly 1 and never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| opcode | input | 3 | Operation select (0 compare, 1 fill, 2 copy fwd, 3 copy back, 4 copy to NUL, 5 scan-until, 6 scan-while) |
| elemSize | input | 2 | Element size for fill and scans: 0 byte, 1 half, 2 word |
| r1In | input | REG_W | Initial destination/scan pointer |
| r2In | input | REG_W | Initial source pointer or comparison value |
| r3In | input | REG_W | Initial element count |
| memRe | output | 1 | Memory read request |
| memWe | output | 1 | Memory write request |
| memAddr | output | REG_W | Byte address of the access |
| memSize | output | 2 | Access width, same encoding as `elemSize` |
| memWdata | output | 32 | Write data, low bytes valid |
| memRdata | input | 32 | Read data, valid one cycle after `memRe` |
| r1Out | output | REG_W | Current R1 value |
| r2Out | output | REG_W | Current R2 value |
| r3Out | output | REG_W | Current R3 value |
| flagZ | output | 1 | Zero condition |
| flagC | output | 1 | Carry condition |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Compare runs use three string pairs:

- equal strings that end in NUL, which separates the NUL stop from the count stop;
- a pair that differs at a later byte with the first side greater;
- the same pair swapped, which shows that carry follows the unsigned order.

Copies run forward, backward and until NUL, both with the NUL inside the count and with the count running out first. This shows the pointer direction and which stop condition applies. Scans run at all three element widths, both hitting and missing the target, so the zero condition of scan-until (element match) is told apart from that of scan-while (remaining count). Zero counts, size 3, opcode 7 and a second start issued mid-operation show that nothing moves that should not.

// File: rtl/str_pkg.sv
package str_pkg;

  localparam int ELEM_W = 32;

  typedef enum logic [2:0] {
    OP_CMP  = 3'd0,
    OP_FILL = 3'd1,
    OP_CPYF = 3'd2,
    OP_CPYB = 3'd3,
    OP_CPYZ = 3'd4,
    OP_SCNU = 3'd5,
    OP_SCNW = 3'd6,
    OP_BAD  = 3'd7
  } strOp_e;

  // strobes from sequencer to datapath, valid for one cycle
  typedef struct packed {
    logic       load;
    logic       rdEn;
    logic       wrEn;
    logic       useR2Addr;
    logic       advR1;
    logic       advR2;
    logic       backward;
    logic       decCnt;
    logic       grabA;
    logic       wrFromMem;
    logic       cmpFlags;
    logic       untilFlags;
    logic       whileFlags;
    logic [1:0] accSize;
  } strobe_t;

endpackage

// File: rtl/str_dpath.sv
module str_dpath
  import str_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [REG_W-1:0]    r1In,
  input  logic [REG_W-1:0]    r2In,
  input  logic [REG_W-1:0]    r3In,
  input  logic [ELEM_W-1:0]   memRdata,
  output logic [REG_W-1:0]    memAddr,
  output logic [ELEM_W-1:0]   memWdata,
  output logic [REG_W-1:0]    r1Out,
  output logic [REG_W-1:0]    r2Out,
  output logic [REG_W-1:0]    r3Out,
  output logic                flagZ,
  output logic                flagC,
  output logic                cntZero,
  output logic                cntOne,
  output logic                cmpHalt,
  output logic                elemEq,
  output logic                nulByte
);

  localparam logic [REG_W-1:0] ONE = REG_W'(1);

  logic [REG_W-1:0]  r1Q, r2Q, r3Q;
  logic [7:0]        capA;
  logic              zQ, cQ;
  logic [REG_W-1:0]  stepAmt;
  logic [ELEM_W-1:0] elemMask;
  logic [ELEM_W-1:0] elemVal;
  logic [ELEM_W-1:0] r2Elem;
  logic              elemLe;

  always_comb begin
    stepAmt = ONE << stb.accSize;
    unique case (stb.accSize)
      2'd0:    elemMask = ELEM_W'(32'h0000_00FF);
      2'd1:    elemMask = ELEM_W'(32'h0000_FFFF);
      default: elemMask = '1;
    endcase
    elemVal = memRdata & elemMask;
    r2Elem  = ELEM_W'(r2Q);
    elemEq  = (elemVal == r2Elem);
    elemLe  = (elemVal <= r2Elem);
    nulByte = (memRdata[7:0] == 8'd0);
    cmpHalt = (capA != memRdata[7:0]) || (capA == 8'd0);
    cntZero = (r3Q == '0);
    cntOne  = (r3Q == ONE);
    memAddr = stb.useR2Addr ? r2Q : r1Q;
    memWdata = stb.wrFromMem ? {{(ELEM_W-8){1'b0}}, memRdata[7:0]}
                             : (r2Elem & elemMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r1Q  <= '0;
      r2Q  <= '0;
      r3Q  <= '0;
      capA <= '0;
      zQ   <= 1'b0;
      cQ   <= 1'b0;
    end else if (stb.load) begin
      r1Q <= r1In;
      r2Q <= r2In;
      r3Q <= r3In;
    end else begin
      if (stb.advR1) r1Q <= stb.backward ? r1Q - stepAmt : r1Q + stepAmt;
      if (stb.advR2) r2Q <= stb.backward ? r2Q - stepAmt : r2Q + stepAmt;
      if (stb.decCnt) r3Q <= r3Q - ONE;
      if (stb.grabA) capA <= memRdata[7:0];
      if (stb.cmpFlags) begin
        zQ <= (capA == memRdata[7:0]);
        cQ <= (capA >= memRdata[7:0]);
      end
      if (stb.untilFlags) begin
        zQ <= elemEq;
        cQ <= elemLe;
      end
      if (stb.whileFlags) begin
        zQ <= cntOne;   // count is about to drop to zero
        cQ <= elemLe;
      end
    end
  end

  assign r1Out = r1Q;
  assign r2Out = r2Q;
  assign r3Out = r3Q;
  assign flagZ = zQ;
  assign flagC = cQ;

endmodule

// File: rtl/str_ctrl.sv
module str_ctrl
  import str_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opcode,
  input  logic [1:0] elemSize,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       cmpHalt,
  input  logic       elemEq,
  input  logic       nulByte,
  output strobe_t    stb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [3:0] {
    S_IDLE, S_DISP, S_CMPA, S_CMPB, S_CMPE, S_FILL,
    S_CPRD, S_CPWR, S_SCRD, S_SCEV, S_DONE
  } state_e;

  state_e     st, stNext;
  strOp_e     opQ;
  logic [1:0] sizeQ;
  logic       sizedOp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= S_IDLE;
      opQ   <= OP_CMP;
      sizeQ <= 2'd0;
    end else begin
      st <= stNext;
      if (st == S_IDLE && start) begin
        opQ   <= strOp_e'(opcode);
        sizeQ <= elemSize;
      end
    end
  end

  assign sizedOp = (opQ == OP_FILL) || (opQ == OP_SCNU) || (opQ == OP_SCNW);

  always_comb begin
    stb          = '0;
    stNext       = st;
    stb.accSize  = sizedOp ? sizeQ : 2'd0;
    stb.backward = (opQ == OP_CPYB);
    unique case (st)
      S_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stNext   = S_DISP;
        end
      end
      S_DISP: begin
        if (cntZero || sizeQ == 2'd3) begin
          stNext = S_DONE;
        end else begin
          unique case (opQ)
            OP_CMP:                   stNext = S_CMPA;
            OP_FILL:                  stNext = S_FILL;
            OP_CPYF, OP_CPYB, OP_CPYZ: stNext = S_CPRD;
            OP_SCNU, OP_SCNW:         stNext = S_SCRD;
            default:                  stNext = S_DONE;
          endcase
        end
      end
      S_CMPA: begin
        stb.rdEn = 1'b1;
        stNext   = S_CMPB;
      end
      S_CMPB: begin
        stb.grabA     = 1'b1;
        stb.rdEn      = 1'b1;
        stb.useR2Addr = 1'b1;
        stNext        = S_CMPE;
      end
      S_CMPE: begin
        stb.cmpFlags = 1'b1;
        stb.advR1    = 1'b1;
        stb.advR2    = 1'b1;
        stb.decCnt   = 1'b1;
        stNext       = (cmpHalt || cntOne) ? S_DONE : S_CMPA;
      end
      S_FILL: begin
        stb.wrEn   = 1'b1;
        stb.advR1  = 1'b1;
        stb.decCnt = 1'b1;
        stNext     = cntOne ? S_DONE : S_FILL;
      end
      S_CPRD: begin
        stb.rdEn      = 1'b1;
        stb.useR2Addr = 1'b1;
        stNext        = S_CPWR;
      end
      S_CPWR: begin
        stb.wrEn      = 1'b1;
        stb.wrFromMem = 1'b1;
        stb.advR1     = 1'b1;
        stb.advR2     = 1'b1;
        stb.decCnt    = 1'b1;
        stNext = (cntOne || (opQ == OP_CPYZ && nulByte)) ? S_DONE : S_CPRD;
      end
      S_SCRD: begin
        stb.rdEn = 1'b1;
        stNext   = S_SCEV;
      end
      S_SCEV: begin
        stb.advR1  = 1'b1;
        stb.decCnt = 1'b1;
        if (opQ == OP_SCNU) begin
          stb.untilFlags = 1'b1;
          stNext = (elemEq || cntOne) ? S_DONE : S_SCRD;
        end else begin
          stb.whileFlags = 1'b1;
          stNext = (!elemEq || cntOne) ? S_DONE : S_SCRD;
        end
      end
      S_DONE:  stNext = S_IDLE;
      default: stNext = S_IDLE;
    endcase
  end

  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE);

endmodule

// File: rtl/str_engine.sv
module str_engine
  import str_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opcode,
  input  logic [1:0]        elemSize,
  input  logic [REG_W-1:0]  r1In,
  input  logic [REG_W-1:0]  r2In,
  input  logic [REG_W-1:0]  r3In,
  output logic              memRe,
  output logic              memWe,
  output logic [REG_W-1:0]  memAddr,
  output logic [1:0]        memSize,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  output logic [REG_W-1:0]  r1Out,
  output logic [REG_W-1:0]  r2Out,
  output logic [REG_W-1:0]  r3Out,
  output logic              flagZ,
  output logic              flagC,
  output logic              busy,
  output logic              done
);

  strobe_t stb;
  logic    cntZero, cntOne, cmpHalt, elemEq, nulByte;

  str_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opcode   (opcode),
    .elemSize (elemSize),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .cmpHalt  (cmpHalt),
    .elemEq   (elemEq),
    .nulByte  (nulByte),
    .stb      (stb),
    .busy     (busy),
    .done     (done)
  );

  str_dpath #(.REG_W(REG_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .r1In     (r1In),
    .r2In     (r2In),
    .r3In     (r3In),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .r1Out    (r1Out),
    .r2Out    (r2Out),
    .r3Out    (r3Out),
    .flagZ    (flagZ),
    .flagC    (flagC),
    .cntZero  (cntZero),
    .cntOne   (cntOne),
    .cmpHalt  (cmpHalt),
    .elemEq   (elemEq),
    .nulByte  (nulByte)
  );

  assign memRe   = stb.rdEn;
  assign memWe   = stb.wrEn;
  assign memSize = stb.accSize;

endmodule

// File: rtl/str_engine_chk.sv
module str_engine_chk #(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             memRe,
  input logic             memWe,
  input logic [REG_W-1:0] r3Out,
  input logic             flagZ,
  input logic             flagC,
  input logic             busy,
  input logic             done
);

  // R10: one access kind per cycle
  p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R9: done lasts one cycle and only while busy
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R9: flags hold across an idle cycle
  p_flags_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(flagZ) && $stable(flagC)));

  // R1: no memory traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRe && !memWe));

  // R12: count only steps down by one while running
  p_r3_step_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |->
      (r3Out == $past(r3Out) || r3Out == $past(r3Out) - 1'b1));

  // R12: count never wraps from zero
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && $past(r3Out) == '0) |-> (r3Out == '0));

endmodule

bind str_engine str_engine_chk #(.REG_W(REG_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .memRe (memRe),
  .memWe (memWe),
  .r3Out (r3Out),
  .flagZ (flagZ),
  .flagC (flagC),
  .busy  (busy),
  .done  (done)
);

// File: tb/str_engine_tb.sv
module str_engine_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  opcode;
  logic [1:0]  elemSize;
  logic [31:0] r1In, r2In, r3In;
  logic        memRe, memWe;
  logic [31:0] memAddr;
  logic [1:0]  memSize;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic [31:0] r1Out, r2Out, r3Out;
  logic        flagZ, flagC, busy, done;

  always #5 clk = ~clk;

  str_engine #(.REG_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .elemSize(elemSize),
    .r1In(r1In), .r2In(r2In), .r3In(r3In),
    .memRe(memRe), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata),
    .r1Out(r1Out), .r2Out(r2Out), .r3Out(r3Out),
    .flagZ(flagZ), .flagC(flagC), .busy(busy), .done(done)
  );

  logic [7:0] mem    [0:255];
  logic [7:0] refMem [0:255];
  int  errors = 0;
  int  checks = 0;
  bit  overlap = 0;
  logic mZ = 1'b0, mC = 1'b0;

  // memory model: one-cycle read latency, little-endian, 256-byte wrap
  always @(posedge clk) begin
    if (memRe) begin
      logic [31:0] v;
      v = '0;
      for (int i = 0; i < (1 << memSize); i++)
        v[8*i +: 8] = mem[8'(memAddr[7:0] + 8'(i))];
      memRdata <= v;
    end
    if (memWe)
      for (int i = 0; i < (1 << memSize); i++)
        mem[8'(memAddr[7:0] + 8'(i))] <= memWdata[8*i +: 8];
  end

  always @(negedge clk) if (rstN && memRe && memWe) overlap = 1;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic put(input int addr, input logic [7:0] b);
    mem[addr[7:0]]    = b;
    refMem[addr[7:0]] = b;
  endtask

  // behavioural reference, then drive and compare
  task automatic runOp(input int op, input int sz, input logic [31:0] a1,
                       input logic [31:0] a2, input logic [31:0] a3, input bit poke);
    logic [31:0] e1 = a1, e2 = a2, e3 = a3, el;
    logic eZ = mZ, eC = mC;
    logic [7:0] x, y;
    int n = 0, k = 2, nb = 1 << sz, lat = 0, bad = 0;
    bit stop = 0, seen = 0;
    string rt, ft;

    if (op == 0) k = 3; else if (op == 1) k = 1;
    case (op)
      0: begin rt = "R2"; ft = "R3"; end
      1: begin rt = "R4"; ft = "R4"; end
      2, 3: begin rt = "R5"; ft = "R5"; end
      4: begin rt = "R6"; ft = "R6"; end
      5: begin rt = "R7"; ft = "R7"; end
      default: begin rt = "R8"; ft = "R8"; end
    endcase

    if (sz == 3 || op == 7 || a3 == 0) begin
      rt = "R1"; ft = "R1";
    end else begin
      while (!stop) begin
        case (op)
          0: begin
            x = refMem[e1[7:0]]; y = refMem[e2[7:0]];
            e1++; e2++; e3--; n++;
            eZ = (x == y); eC = (x >= y);
            stop = (x != y) || (x == 8'd0) || (e3 == 0);
          end
          1: begin
            for (int i = 0; i < nb; i++) refMem[8'(e1[7:0] + 8'(i))] = e2[8*i +: 8];
            e1 += nb; e3--; n++;
            stop = (e3 == 0);
          end
          2, 3, 4: begin
            x = refMem[e2[7:0]];
            refMem[e1[7:0]] = x;
            if (op == 3) begin e1--; e2--; end else begin e1++; e2++; end
            e3--; n++;
            stop = (e3 == 0) || (op == 4 && x == 8'd0);
          end
          default: begin
            el = '0;
            for (int i = 0; i < nb; i++) el[8*i +: 8] = refMem[8'(e1[7:0] + 8'(i))];
            e1 += nb; e3--; n++;
            eC = (el <= e2);
            if (op == 5) begin
              eZ = (el == e2); stop = (el == e2) || (e3 == 0);
            end else begin
              eZ = (e3 == 0); stop = (el != e2) || (e3 == 0);
            end
          end
        endcase
      end
    end

    @(negedge clk);
    opcode = op[2:0]; elemSize = sz[1:0];
    r1In = a1; r2In = a2; r3In = a3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (done) seen = 1;
      else if (poke && lat == 1) begin
        start = 1'b1; opcode = 3'd1; r1In = 32'hF0; r3In = 32'd9;   // must be ignored (R9)
      end else start = 1'b0;
    end
    start = 1'b0;
    check("R10", "cycles to done", lat, 1 + n * k);
    check(rt, "r1", r1Out, e1);
    check(rt, "r2", r2Out, e2);
    check(rt, "r3 (R12 no wrap)", r3Out, e3);
    check(ft, "zero", {31'd0, flagZ}, {31'd0, eZ});
    check(ft, "carry", {31'd0, flagC}, {31'd0, eC});
    for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
    check(rt, "memory bytes differing", bad, 0);
    @(negedge clk);
    check("R9", "done after pulse", {31'd0, done}, 0);
    check("R9", "busy after done", {31'd0, busy}, 0);
    mZ = eZ; mC = eC;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; opcode = '0; elemSize = '0;
    r1In = '0; r2In = '0; r3In = '0;
    for (int i = 0; i < 256; i++) put(i, 8'(((i * 37 + 11) & 8'h7F) | 1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11", "r1", r1Out, 0);
    check("R11", "r3", r3Out, 0);
    check("R11", "flags", {30'd0, flagZ, flagC}, 0);
    check("R11", "done/busy", {30'd0, done, busy}, 0);
    check("R11", "mem req", {30'd0, memRe, memWe}, 0);

    put(8'h10, 8'h61); put(8'h11, 8'h62); put(8'h12, 8'h63); put(8'h13, 8'h00);
    put(8'h20, 8'h61); put(8'h21, 8'h62); put(8'h22, 8'h63); put(8'h23, 8'h00);
    put(8'h30, 8'h61); put(8'h31, 8'h62); put(8'h32, 8'h64);

    runOp(0, 0, 32'h10, 32'h20, 32'd10, 0);   // stop on NUL, equal
    runOp(0, 0, 32'h10, 32'h20, 32'd0,  0);   // R1 zero count keeps flags
    runOp(0, 0, 32'h30, 32'h20, 32'd10, 1);   // mismatch, R1 side greater
    runOp(0, 0, 32'h20, 32'h30, 32'd10, 0);   // mismatch, R1 side smaller
    runOp(0, 0, 32'h10, 32'h20, 32'd2,  0);   // count runs out
    runOp(1, 0, 32'h80, 32'h0000_00A5, 32'd3, 0);
    runOp(1, 1, 32'h90, 32'h0000_1234, 32'd2, 0);
    runOp(1, 2, 32'hA0, 32'hDEAD_BEEF, 32'd2, 1);
    runOp(1, 0, 32'h60, 32'h77, 32'd0, 0);    // R1 fill with zero count
    runOp(2, 0, 32'hB0, 32'h10, 32'd6, 0);
    runOp(3, 0, 32'hCF, 32'h3F, 32'd5, 1);
    runOp(4, 0, 32'hD0, 32'h20, 32'd10, 0);   // stop after NUL
    runOp(4, 0, 32'hE0, 32'h10, 32'd2, 0);    // count before NUL
    runOp(5, 0, 32'h10, 32'h63, 32'd8, 0);    // found
    runOp(5, 1, 32'h90, 32'h9999, 32'd2, 0);  // not found
    runOp(5, 0, 32'h10, 32'h63, 32'd0, 0);    // R1 zero count
    runOp(6, 2, 32'hA0, 32'hDEAD_BEEF, 32'd4, 0); // differs with count left
    runOp(6, 0, 32'h80, 32'hA5, 32'd3, 0);    // runs out, zero set
    runOp(6, 0, 32'h80, 32'hA5, 32'd0, 0);    // R1 zero count
    runOp(1, 3, 32'h40, 32'h11, 32'd4, 0);    // R1 size 3 illegal
    runOp(7, 0, 32'h40, 32'h11, 32'd4, 0);    // R1 opcode 7 illegal
    check("R10", "read and write together", {31'd0, overlap}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule